// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a two-channel, two's-complement serial audio stream into parallel samples. The stream arrives as a data line, a word clock and a bit-clock rising-edge strobe. All three are already synchronised to the system clock. Two 2-bit selects set how a word sits inside each half frame and how many bits it has. The supported placements are right-aligned MSB-first, right-aligned LSB-first, left-aligned, and the I2S placement with a one-bit delay. Word lengths are 16, 20 or 24 bits.

A half frame ends when the word clock is seen at a new level. At that point the receiver delivers the word it has just collected as a 24-bit left-aligned value. Shorter words carry zeros in their low bits. The sample comes with a left/right flag and a one-cycle valid pulse. A separate one-cycle pulse marks any change of the two selects, so downstream logic can discard samples taken across a format switch.

Top module: `audio_serial_rx`

## Requirements
- R1: With `pos_sel` = 00 (right-aligned, MSB first), the word is the last N bits sampled before the word clock changes level, the first of those N bits being the MSB.
- R2: With `pos_sel` = 01 (right-aligned, LSB first), the word is the last N bits before the level change, and the first of those N bits becomes bit 0 of the word.
- R3: With `pos_sel` = 10 (left-aligned), the MSB is the bit sampled on the first strobe at the new word-clock level; bits after the N-th are ignored.
- R4: With `pos_sel` = 11 (I2S), the MSB is the bit sampled on the second strobe at the new level, and a half frame with the word clock low is the left channel.
- R5: `len_sel` sets N: 00 gives 16 bits, 10 gives 20 bits, 01 and 11 both give 24 bits. The word occupies `smp_data[23:24-N]`, and the bits below it are zero.
- R6: Outside I2S mode, a half frame with the word clock high is the left channel (`smp_left` = 1). The flag always describes the half frame that has just ended.
- R7: `smp_valid` pulses for one cycle, one cycle after the strobe on which the new word-clock level is first sampled. There is one pulse per half frame and none for the partial half frame that follows reset. `smp_data` and `smp_left` hold between pulses.
- R8: `fmt_changed` is high for exactly one cycle, one cycle after either `pos_sel` or `len_sel` takes a new value.
- R9: During reset and in the first cycle after it, `smp_valid`, `fmt_changed` and `smp_data` are 0.
- R10: Half frames of 24 and of 32 bit clocks (48 and 64 per stereo frame) both decode correctly in every mode whose word fits the half frame.
- R11: `wclk` and `sdata` are ignored in cycles without `bit_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe for each bit-clock rising edge |
| wclk | input | 1 | Word clock level, valid with the strobe |
| sdata | input | 1 | Serial data bit, valid with the strobe |
| pos_sel | input | 2 | Word placement select |
| len_sel | input | 2 | Word length select |
| smp_valid | output | 1 | One-cycle pulse when a new sample is presented |
| smp_data | output | 24 | Left-aligned two's-complement sample |
| smp_left | output | 1 | 1 when the sample belongs to the left channel |
| fmt_changed | output | 1 | One-cycle pulse after a change of either select |

## Verification
The bench builds the receiver with its default `IDX_W` of 6. The bit-position counter therefore spans half frames of up to 63 bits, so the 24-bit and 32-bit half frames used for stimulus never reach saturation. Every one of the sixteen select combinations runs at both half-frame lengths, except I2S at 24 bits in a 24-clock half. Filler bits around each word are random, and random values are driven on `wclk` and `sdata` between strobes. The stimulus also includes all-ones and sign-only words, which bring bit reversal, zero fill, channel polarity and the post-reset partial half within reach.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int NBITS_W  = 5;

    typedef enum logic [1:0] {
        POS_RJ_MSB = 2'b00,
        POS_RJ_LSB = 2'b01,
        POS_LJ     = 2'b10,
        POS_I2S    = 2'b11
    } pos_mode_e;

    typedef struct packed {
        pos_mode_e          pos;
        logic [NBITS_W-1:0] nbits;
    } fmt_cfg_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] data;
        logic                left;
    } sample_t;

    // Non-binary length code: two codes map to the full width.
    function automatic logic [NBITS_W-1:0] len_decode(input logic [1:0] code);
        case (code)
            2'b00:   return NBITS_W'(16);
            2'b10:   return NBITS_W'(20);
            default: return NBITS_W'(24);
        endcase
    endfunction

    // Mask keeping the upper n bits of a sample.
    function automatic logic [SAMPLE_W-1:0] top_mask(input logic [NBITS_W-1:0] n);
        logic [SAMPLE_W-1:0] ones;
        ones = '1;
        return ~(ones >> n);
    endfunction

endpackage

// File: rtl/asrx_fmt_ctrl.sv
module asrx_fmt_ctrl
    import asrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pos_sel,
    input  logic [1:0] len_sel,
    output fmt_cfg_t   cfg,
    output logic       fmt_changed
);
    logic [1:0] pos_q;
    logic [1:0] len_q;

    always_comb begin
        cfg.pos   = pos_mode_e'(pos_sel);
        cfg.nbits = len_decode(len_sel);
    end

    always_ff @(posedge clk) begin
        pos_q <= pos_sel;
        len_q <= len_sel;
        if (rst) begin
            fmt_changed <= 1'b0;
        end else begin
            fmt_changed <= (pos_sel != pos_q) || (len_sel != len_q);
        end
    end

endmodule

// File: rtl/asrx_frame_track.sv
module asrx_frame_track #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_stb,
    input  logic             wclk,
    output logic             trans,
    output logic             emit,
    output logic [IDX_W-1:0] idx_now,
    output logic             prev_level
);
    localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic             primed;
    logic             seen;
    logic             wclk_q;
    logic [IDX_W-1:0] bit_idx;

    assign trans      = bit_stb && primed && (wclk != wclk_q);
    assign emit       = trans && seen;
    assign idx_now    = trans ? '0 : bit_idx;
    assign prev_level = wclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed  <= 1'b0;
            seen    <= 1'b0;
            wclk_q  <= 1'b0;
            bit_idx <= '0;
        end else if (bit_stb) begin
            primed <= 1'b1;
            wclk_q <= wclk;
            if (trans) begin
                seen    <= 1'b1;
                bit_idx <= IDX_ONE;
            end else if (bit_idx != IDX_MAX) begin
                bit_idx <= bit_idx + IDX_ONE;
            end
        end
    end

endmodule

// File: rtl/asrx_word_capture.sv
module asrx_word_capture
    import asrx_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_stb,
    input  logic                sdata,
    input  logic                trans,
    input  logic [IDX_W-1:0]    idx_now,
    input  fmt_cfg_t            cfg,
    output logic [SAMPLE_W-1:0] word
);
    logic [SAMPLE_W-1:0] sr_msb;
    logic [SAMPLE_W-1:0] sr_lsb;
    logic [SAMPLE_W-1:0] cap;
    logic [SAMPLE_W-1:0] cap_nxt;
    int                  lead;
    int                  slot;

    // Front-anchored capture for left-aligned and I2S placement.
    always_comb begin
        lead    = (cfg.pos == POS_I2S) ? 1 : 0;
        slot    = int'(idx_now) - lead;
        cap_nxt = trans ? '0 : cap;
        if (slot >= 0 && slot < int'(cfg.nbits)) begin
            cap_nxt[SAMPLE_W-1-slot] = sdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_msb <= '0;
            sr_lsb <= '0;
            cap    <= '0;
        end else if (bit_stb) begin
            sr_msb <= {sr_msb[SAMPLE_W-2:0], sdata};
            sr_lsb <= {sdata, sr_lsb[SAMPLE_W-1:1]};
            cap    <= cap_nxt;
        end
    end

    // Word of the half frame that is closing, before this bit is taken in.
    always_comb begin
        case (cfg.pos)
            POS_RJ_MSB: word = sr_msb << (SAMPLE_W - int'(cfg.nbits));
            POS_RJ_LSB: word = sr_lsb & top_mask(cfg.nbits);
            default:    word = cap;
        endcase
    end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import asrx_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_stb,
    input  logic        wclk,
    input  logic        sdata,
    input  logic [1:0]  pos_sel,
    input  logic [1:0]  len_sel,
    output logic        smp_valid,
    output logic [23:0] smp_data,
    output logic        smp_left,
    output logic        fmt_changed
);
    fmt_cfg_t            cfg;
    logic                trans;
    logic                emit;
    logic [IDX_W-1:0]    idx_now;
    logic                prev_level;
    logic [SAMPLE_W-1:0] word;
    sample_t             out_q;
    logic                valid_q;

    asrx_fmt_ctrl u_fmt (
        .clk         (clk),
        .rst         (rst),
        .pos_sel     (pos_sel),
        .len_sel     (len_sel),
        .cfg         (cfg),
        .fmt_changed (fmt_changed)
    );

    asrx_frame_track #(.IDX_W(IDX_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .bit_stb    (bit_stb),
        .wclk       (wclk),
        .trans      (trans),
        .emit       (emit),
        .idx_now    (idx_now),
        .prev_level (prev_level)
    );

    asrx_word_capture #(.IDX_W(IDX_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .bit_stb (bit_stb),
        .sdata   (sdata),
        .trans   (trans),
        .idx_now (idx_now),
        .cfg     (cfg),
        .word    (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= emit;
            if (emit) begin
                out_q.data <= word;
                out_q.left <= (cfg.pos == POS_I2S) ? ~prev_level : prev_level;
            end
        end
    end

    assign smp_valid = valid_q;
    assign smp_data  = out_q.data;
    assign smp_left  = out_q.left;

endmodule

// File: rtl/asrx_rx_checker.sv
module asrx_rx_checker (
    input logic        clk,
    input logic        rst,
    input logic        bit_stb,
    input logic        wclk,
    input logic [1:0]  pos_sel,
    input logic [1:0]  len_sel,
    input logic        smp_valid,
    input logic [23:0] smp_data,
    input logic        smp_left,
    input logic        fmt_changed
);
    a_r7_valid_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> $past(bit_stb));

    a_r7_output_hold: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |-> ($stable(smp_data) && $stable(smp_left)));

    a_r6_left_polarity: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && $past(pos_sel) != 2'b11) |-> (smp_left == !$past(wclk)));

    a_r4_i2s_polarity: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && $past(pos_sel) == 2'b11) |-> (smp_left == $past(wclk)));

    a_r5_zero_fill_16: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && $past(len_sel) == 2'b00) |-> (smp_data[7:0] == 8'h00));

    a_r5_zero_fill_20: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && $past(len_sel) == 2'b10) |-> (smp_data[3:0] == 4'h0));

    a_r8_change_pulse: assert property (@(posedge clk) disable iff (rst)
        fmt_changed == (($past(pos_sel) != $past(pos_sel, 2)) ||
                        ($past(len_sel) != $past(len_sel, 2))));

    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!smp_valid && !fmt_changed && smp_data == 24'h0));

endmodule

bind audio_serial_rx asrx_rx_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .bit_stb     (bit_stb),
    .wclk        (wclk),
    .pos_sel     (pos_sel),
    .len_sel     (len_sel),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .smp_left    (smp_left),
    .fmt_changed (fmt_changed)
);

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_stb;
    logic        wclk;
    logic        sdata;
    logic [1:0]  pos_sel;
    logic [1:0]  len_sel;
    logic        smp_valid;
    logic [23:0] smp_data;
    logic        smp_left;
    logic        fmt_changed;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    audio_serial_rx dut_i (
        .clk         (clk),
        .rst         (rst),
        .bit_stb     (bit_stb),
        .wclk        (wclk),
        .sdata       (sdata),
        .pos_sel     (pos_sel),
        .len_sel     (len_sel),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .smp_left    (smp_left),
        .fmt_changed (fmt_changed)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b10:   return 20;
            default: return 24;
        endcase
    endfunction

    function automatic string pos_tag(input int pos);
        case (pos)
            0:       return "R1";
            1:       return "R2";
            2:       return "R3";
            default: return "R4";
        endcase
    endfunction

    // Serial bit i of a half frame of H bits carrying the N-bit word w.
    function automatic logic bit_for(input int pos, input int n, input int h,
                                     input int i, input logic [23:0] w, input logic rnd);
        case (pos)
            0: if (i >= h - n) return w[n-1-(i-(h-n))];
            1: if (i >= h - n) return w[i-(h-n)];
            2: if (i < n) return w[n-1-i];
            default: if (i >= 1 && i <= n) return w[n-i];
        endcase
        return rnd;
    endfunction

    task automatic do_reset();
        rst     = 1'b1;
        bit_stb = 1'b0;
        wclk    = 1'b0;
        sdata   = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    // Called at a negedge; returns at a negedge.
    task automatic send_bit(input logic wc, input logic d, output logic v,
                            output logic [23:0] dat, output logic lft, inout int idle_v);
        bit_stb = 1'b1;
        wclk    = wc;
        sdata   = d;
        @(negedge clk);
        v   = smp_valid;
        dat = smp_data;
        lft = smp_left;
        bit_stb = 1'b0;
        wclk    = 1'($urandom);
        sdata   = 1'($urandom);
        @(negedge clk);
        if (smp_valid) idle_v++;
    endtask

    task automatic run_stream(input int pos, input int lsel, input int h, input int nh);
        int          n;
        logic        l0;
        logic        v;
        logic        lft;
        logic        lvl;
        logic [23:0] dat;
        logic [23:0] w;
        logic [23:0] mask;
        logic [23:0] exp_prev;
        logic        left_prev;
        bit          have_prev;
        int          idle_v;
        int          extra;
        pos_sel = 2'(pos);
        len_sel = 2'(lsel);
        do_reset();
        n         = len_of(2'(lsel));
        mask      = 24'hFFFFFF >> (24 - n);
        l0        = 1'($urandom);
        idle_v    = 0;
        extra     = 0;
        have_prev = 1'b0;
        exp_prev  = '0;
        left_prev = 1'b0;
        for (int i = 0; i < 3; i++) begin
            send_bit(l0, 1'($urandom), v, dat, lft, idle_v);
            if (v) extra++;
        end
        for (int k = 0; k <= nh; k++) begin
            lvl = (k % 2 == 0) ? ~l0 : l0;
            if (k == 0)      w = mask;
            else if (k == 1) w = 24'h1 << (n - 1);
            else             w = 24'($urandom) & mask;
            for (int i = 0; i < ((k == nh) ? 1 : h); i++) begin
                send_bit(lvl, bit_for(pos, n, h, i, w, 1'($urandom)), v, dat, lft, idle_v);
                if (i == 0) begin
                    if (have_prev) begin
                        check(v == 1'b1, "R7", "valid at half boundary", 32'(v), 32'd1);
                        check(dat == exp_prev, {pos_tag(pos), " R5 R10"},
                              $sformatf("word pos=%0d len=%0d half=%0d", pos, lsel, h),
                              32'(dat), 32'(exp_prev));
                        check(lft == left_prev, (pos == 3) ? "R4" : "R6",
                              "channel flag", 32'(lft), 32'(left_prev));
                    end else begin
                        check(v == 1'b0, "R7", "no word for partial half", 32'(v), 32'd0);
                    end
                end else if (v) begin
                    extra++;
                end
            end
            exp_prev  = w << (24 - n);
            left_prev = (pos == 3) ? ~lvl : lvl;
            have_prev = 1'b1;
        end
        check(extra == 0, "R7", "valid away from boundary", 32'(extra), 32'd0);
        check(idle_v == 0, "R11", "valid after idle cycle", 32'(idle_v), 32'd0);
    endtask

    initial begin
        void'($urandom(32'h5EED_2024));
        pos_sel = 2'b00;
        len_sel = 2'b00;
        do_reset();
        // R9: reset state
        check(smp_valid == 1'b0, "R9", "valid after reset", 32'(smp_valid), 32'd0);
        check(smp_data == 24'h0, "R9", "data after reset", 32'(smp_data), 32'd0);
        check(fmt_changed == 1'b0, "R9", "fmt_changed after reset", 32'(fmt_changed), 32'd0);

        // R8: select change pulses
        pos_sel = 2'b10;
        @(negedge clk);
        check(fmt_changed == 1'b1, "R8", "pulse on pos change", 32'(fmt_changed), 32'd1);
        @(negedge clk);
        check(fmt_changed == 1'b0, "R8", "pulse is one cycle", 32'(fmt_changed), 32'd0);
        len_sel = 2'b11;
        @(negedge clk);
        check(fmt_changed == 1'b1, "R8", "pulse on len change", 32'(fmt_changed), 32'd1);
        @(negedge clk);
        check(fmt_changed == 1'b0, "R8", "pulse ends", 32'(fmt_changed), 32'd0);
        repeat (3) @(negedge clk);
        check(fmt_changed == 1'b0, "R8", "no pulse when stable", 32'(fmt_changed), 32'd0);

        // R1..R6, R10, R11 over all selects and both half lengths
        for (int p = 0; p < 4; p++) begin
            for (int ls = 0; ls < 4; ls++) begin
                for (int hs = 0; hs < 2; hs++) begin
                    int hh;
                    hh = (hs == 0) ? 24 : 32;
                    if (p == 3 && len_of(2'(ls)) == 24 && hh == 24) hh = 32;
                    run_stream(p, ls, hh, 5);
                end
            end
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule